// File: doc/BRIEF.md
# PWM Emergency Shutdown Guard

This block sits between a PWM channel and its output pin. It watches an external fault input. When the guard is enabled and the fault input reaches its programmed active level, the block replaces the PWM waveform with a fixed safe level. The trip is latched: the pin returning to its idle level does not release the output by itself.

Release takes two conditions and then a period boundary. First, a restart request must have been seen. Second, the fault input must be idle again. When both hold, the block issues a one-cycle pulse that clears the channel counters. It then waits for the next period-start strobe from the counters before the PWM waveform passes through again.

The block also keeps a sticky fault flag, which is cleared by writing 1. It raises an interrupt request when interrupts are enabled. It exposes the synchronised level of the fault input as a live status bit.

Top module: `pwm_guard`

## Requirements
- R1: While `guard_en` is 0 the fault input is ignored. `pwm_out` equals `pwm_in` one cycle later, and `trip_flag` is never set. Clearing `guard_en` while tripped returns to pass-through at the next edge.
- R2: `pin_pol` selects the active level of the fault input: 1 means high is active, 0 means low is active. The idle level never trips the guard.
- R3: The fault input passes through a two-stage synchroniser. `pin_state` shows the raw input level two clock edges after a change, whether or not the guard is enabled.
- R4: With the guard enabled, an active fault input forces `pwm_out` to `safe_lvl` on the third clock edge after the input changes. The output stays at `safe_lvl` while tripped, whatever `pwm_in` does.
- R5: `trip_flag` is set on the same edge as the trip, and is set again on every cycle the fault stays active. Asserting `flag_clr` clears it on the next edge. If an active detection arrives in the same cycle, the set wins.
- R6: `irq` equals `trip_flag` AND `irq_en`, and is updated on the same edge as the flag.
- R7: While tripped, the block remembers a `restart_req` pulse. The restart is accepted on the first edge where a restart has been seen and the synchronised fault input is idle. `cnt_clr` is high for exactly the one cycle after that edge. Without a restart, an idle fault input never releases the trip.
- R8: After acceptance, `pwm_out` stays at `safe_lvl` until an edge with `period_start` high; at that edge `pwm_out` takes `pwm_in`. An active fault while waiting trips the guard again, and `period_start` then has no effect.
- R9: A `restart_req` while not tripped has no effect: `cnt_clr` stays 0.
- R10: After reset, `pwm_out`, `trip_flag`, `irq`, `cnt_clr` and `pin_state` are all 0. In pass-through, `pwm_out` follows `pwm_in` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous fault input |
| guard_en | input | 1 | Enables the shutdown function |
| pin_pol | input | 1 | Active level of the fault input (1 = high) |
| safe_lvl | input | 1 | Level forced onto the output while shut down |
| irq_en | input | 1 | Lets the flag drive the interrupt request |
| restart_req | input | 1 | One-cycle request to leave shutdown |
| flag_clr | input | 1 | Write-1-to-clear strobe for the flag |
| period_start | input | 1 | Strobe from the channel counter at the start of a period |
| pwm_in | input | 1 | Normal PWM waveform |
| pwm_out | output | 1 | Guarded PWM output (registered) |
| trip_flag | output | 1 | Sticky fault flag |
| irq | output | 1 | Interrupt request |
| pin_state | output | 1 | Synchronised live level of the fault input |
| cnt_clr | output | 1 | One-cycle counter clear on restart acceptance |

## Verification
Results arrive at different edges, and the bench samples each one there:
- `pin_state` is due two edges after a fault input change.
- The trip, the flag and `irq` are due on the third edge.
- `pwm_out` follows `pwm_in` one edge later.
- `cnt_clr` appears one edge after acceptance. Acceptance itself falls on the third edge after the input goes idle when the restart came earlier.
- Release happens on the edge that samples `period_start`.

The bench drives inputs on falling edges and steps a fixed number of rising edges before sampling each result. For every delayed result it also samples one edge early, so that a result arriving too soon is caught.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;
  typedef enum logic [1:0] {
    GS_RUN  = 2'd0,
    GS_TRIP = 2'd1,
    GS_WAIT = 2'd2
  } gstate_t;
endpackage

// File: rtl/pwm_guard_sync.sv
module pwm_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pwm_guard_fsm.sv
module pwm_guard_fsm
  import pwm_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  logic    active,
  input  logic    restart_req,
  input  logic    period_start,
  output gstate_t st_q,
  output gstate_t st_nx,
  output logic    cnt_clr
);
  logic pend_q, pend_nx, accept;

  always_comb begin
    st_nx   = st_q;
    pend_nx = pend_q;
    if (!enable) begin
      st_nx   = GS_RUN;
      pend_nx = 1'b0;
    end else begin
      case (st_q)
        GS_RUN: begin
          pend_nx = 1'b0;
          if (active) st_nx = GS_TRIP;
        end
        GS_TRIP: begin
          if (restart_req) pend_nx = 1'b1;
          if ((restart_req || pend_q) && !active) begin
            st_nx   = GS_WAIT;
            pend_nx = 1'b0;
          end
        end
        GS_WAIT: begin
          if (active)            st_nx = GS_TRIP;
          else if (period_start) st_nx = GS_RUN;
        end
        default: st_nx = GS_RUN;
      endcase
    end
  end

  assign accept = (st_q == GS_TRIP) && (st_nx == GS_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= GS_RUN;
      pend_q  <= 1'b0;
      cnt_clr <= 1'b0;
    end else begin
      st_q    <= st_nx;
      pend_q  <= pend_nx;
      cnt_clr <= accept;
    end
  end

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> !cnt_clr); // R7
  AST_WAIT_ONLY_FROM_TRIP: assert property (@(posedge clk) disable iff (rst)
    (st_q == GS_WAIT && $past(st_q) != GS_WAIT) |-> $past(st_q) == GS_TRIP); // R7
  AST_ACTIVE_LEAVES_RUN: assert property (@(posedge clk) disable iff (rst)
    active |=> st_q != GS_RUN); // R4
endmodule

// File: rtl/pwm_guard_flag.sv
module pwm_guard_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_nx;

  assign flag_nx = set_i | (flag_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_nx;
      irq_o  <= flag_nx & ie_i;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o); // R6
endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
  import pwm_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic guard_en,
  input  logic pin_pol,
  input  logic safe_lvl,
  input  logic irq_en,
  input  logic restart_req,
  input  logic flag_clr,
  input  logic period_start,
  input  logic pwm_in,
  output logic pwm_out,
  output logic trip_flag,
  output logic irq,
  output logic pin_state,
  output logic cnt_clr
);
  logic    pin_s;
  logic    active;
  gstate_t st_q, st_nx;

  pwm_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  assign pin_state = pin_s;
  assign active    = guard_en && (pin_s == pin_pol);

  pwm_guard_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .enable       (guard_en),
    .active       (active),
    .restart_req  (restart_req),
    .period_start (period_start),
    .st_q         (st_q),
    .st_nx        (st_nx),
    .cnt_clr      (cnt_clr)
  );

  pwm_guard_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (active),
    .clr_i  (flag_clr),
    .ie_i   (irq_en),
    .flag_o (trip_flag),
    .irq_o  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= (st_nx != GS_RUN) ? safe_lvl : pwm_in;
  end

  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!guard_en)) |-> pwm_out == $past(pwm_in)); // R1
  AST_SAFE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q != GS_RUN) |-> pwm_out == $past(safe_lvl)); // R4
  AST_NO_FLAG_OFF: assert property (@(posedge clk) disable iff (rst)
    (!guard_en && !trip_flag) |=> !trip_flag); // R1
endmodule

// File: tb/sim_pwm_guard.sv
module sim_pwm_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_i = 1'b0, guard_en = 1'b0, pin_pol = 1'b0, safe_lvl = 1'b0;
  logic irq_en = 1'b0, restart_req = 1'b0, flag_clr = 1'b0;
  logic period_start = 1'b0, pwm_in = 1'b0;
  logic pwm_out, trip_flag, irq, pin_state, cnt_clr;
  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  pwm_guard u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .guard_en(guard_en),
    .pin_pol(pin_pol), .safe_lvl(safe_lvl), .irq_en(irq_en),
    .restart_req(restart_req), .flag_clr(flag_clr),
    .period_start(period_start), .pwm_in(pwm_in), .pwm_out(pwm_out),
    .trip_flag(trip_flag), .irq(irq), .pin_state(pin_state), .cnt_clr(cnt_clr)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R10 reset pwm_out", pwm_out, 1'b0);
    chk("R10 reset flag", trip_flag, 1'b0);
    chk("R10 reset irq", irq, 1'b0);
    chk("R10 reset cnt_clr", cnt_clr, 1'b0);
    chk("R10 reset pin_state", pin_state, 1'b0);
    rst = 1'b0;

    for (int c = 0; c < 8; c++) begin
      logic act, idle, sf, ie, early;
      act = c[0]; idle = ~c[0]; sf = c[1]; ie = c[2]; early = c[0] ^ c[2];
      // settle with the guard off
      guard_en = 1'b0; pin_pol = act; safe_lvl = sf; irq_en = ie;
      pin_i = idle; flag_clr = 1'b1;
      step(1); flag_clr = 1'b0;
      step(3);
      guard_en = 1'b1;
      // R2/R10: idle level passes the waveform with one cycle latency
      for (int v = 0; v < 2; v++) begin
        pwm_in = v[0]; step(1);
        chk("R10 pass latency", pwm_out, v[0]);
        chk("R2 idle level no trip", trip_flag, 1'b0);
      end
      // R3/R4/R5/R6: trip
      pin_i = act; pwm_in = ~sf;
      step(1);
      chk("R3 status not early", pin_state, idle);
      step(1);
      chk("R3 status after two edges", pin_state, act);
      chk("R3 output not yet forced", pwm_out, ~sf);
      step(1);
      chk("R4 forced to safe level", pwm_out, sf);
      chk("R5 flag set on trip", trip_flag, 1'b1);
      chk("R6 irq follows enable", irq, ie);
      pwm_in = sf; step(1); pwm_in = ~sf; step(1);
      chk("R4 held while tripped", pwm_out, sf);
      // R5: set wins over clear
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      chk("R5 set beats clear", trip_flag, 1'b1);
      if (early) begin
        restart_req = 1'b1; step(1); restart_req = 1'b0;
        chk("R7 no accept while active", cnt_clr, 1'b0);
        chk("R7 still safe while active", pwm_out, sf);
        pin_i = idle; step(3);
        chk("R7 accept after idle", cnt_clr, 1'b1);
      end else begin
        pin_i = idle; step(4);
        chk("R7 idle alone no release", cnt_clr, 1'b0);
        chk("R7 idle alone stays safe", pwm_out, sf);
        restart_req = 1'b1; step(1); restart_req = 1'b0;
        chk("R7 accept on restart", cnt_clr, 1'b1);
      end
      chk("R8 safe after accept", pwm_out, sf);
      step(1);
      chk("R7 clear pulse single", cnt_clr, 1'b0);
      chk("R8 waits for period", pwm_out, sf);
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      chk("R5 flag cleared", trip_flag, 1'b0);
      chk("R6 irq cleared", irq, 1'b0);
      // R8: re-trip while waiting
      pin_i = act; step(3);
      chk("R8 retrip flag", trip_flag, 1'b1);
      period_start = 1'b1; step(1); period_start = 1'b0;
      chk("R8 period ignored when tripped", pwm_out, sf);
      pin_i = idle; restart_req = 1'b1; step(1); restart_req = 1'b0;
      step(2);
      chk("R7 remembered restart", cnt_clr, 1'b1);
      step(2);
      chk("R8 still waiting", pwm_out, sf);
      period_start = 1'b1; step(1); period_start = 1'b0;
      chk("R8 release at period start", pwm_out, ~sf);
      pwm_in = sf; step(1);
      chk("R10 pass after release", pwm_out, sf);
      // R9: restart outside shutdown
      restart_req = 1'b1; step(1); restart_req = 1'b0;
      chk("R9 restart ignored in run", cnt_clr, 1'b0);
      step(1);
      chk("R9 no late clear", cnt_clr, 1'b0);
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      // R1: disabled guard ignores the pin
      guard_en = 1'b0; pin_i = act; pwm_in = ~sf; step(3);
      chk("R1 pass when off", pwm_out, ~sf);
      chk("R1 no flag when off", trip_flag, 1'b0);
      chk("R3 status live when off", pin_state, act);
      pwm_in = sf; step(1);
      chk("R1 follows when off", pwm_out, sf);
      // R1: disabling while tripped
      guard_en = 1'b1; pwm_in = ~sf; step(1);
      chk("R4 immediate trip held pin", pwm_out, sf);
      guard_en = 1'b0; step(1);
      chk("R1 disable releases", pwm_out, ~sf);
    end
    finish_run();
  end
endmodule